// File: doc/BRIEF.md
# DRAM Channel Controller with Page Timing

This block serves one memory channel. Requests (address, byte count, tag) enter a first-in-first-out queue. The request at the head goes to the channel as soon as the channel is idle. It stays at the head until its service ends, so it keeps its queue slot for the whole time it is in service. The time a request needs depends on page state. The controller remembers which row is open in every bank. An access to that open row is charged a short latency. Any other access is charged a longer latency, and the row it touches becomes the bank's open row.

The bank is taken from the address in one of two ways, chosen by a mode input. In row-interleave mode, each page-sized run of addresses moves to the next bank. In block-interleave mode, each cache-block-sized run moves to the next bank. In both modes the row is the address bits above the page offset and the bank field. The bank count is modules × ranks × banks-per-rank for this single channel. Four running counters report channel busy cycles, completed requests, pages opened and bytes moved. Each finished request raises a one-cycle completion pulse that carries its tag.

Top module: `dram_chan_ctrl`

## Requirements
- R1: Requests complete in the order they were accepted, and each completion pulse carries the tag of the request it ends.
- R2: `req_ready` is low exactly when DEPTH (default 4) requests are held. The request in service counts as held until its completion edge. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high.
- R3: An access to the row that is open in its bank keeps the channel busy for T_OPEN (default 2) cycles.
- R4: An access to a bank with no open row, or with a different open row, keeps the channel busy for T_CLOSED (default 5) cycles, and its row then becomes that bank's open row. After reset no bank has an open row.
- R5: With `map_mode` = 0 (row interleave), with the defaults, bank = addr[8:6] and row = addr[23:9]. The page is 64 bytes and there are 8 banks.
- R6: With `map_mode` = 1 (block interleave), with the defaults, bank = addr[6:4] (16-byte cache blocks) and row = addr[23:9].
- R7: At each completion pulse, `cnt_busy` holds the sum of all service latencies so far, `cnt_reqs` the number of completed requests, `cnt_pages` the number of closed-page accesses and `cnt_bytes` the sum of the completed byte counts.
- R8: After reset `req_ready` = 1, `done_valid` = 0 and all four counters are zero.
- R9: Service of a request starts on the first edge after both of these hold: the request was accepted, and the previous request completed. It completes on the edge L cycles later, where L is its latency. `done_valid` is high for the single cycle after that completion edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_mode | input | 1 | 0 = row interleave, 1 = cache-block interleave |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue can take a request |
| req_addr | input | 24 | Byte address of the request |
| req_bytes | input | 8 | Bytes moved by the request |
| req_tag | input | 4 | Identifier returned on completion |
| done_valid | output | 1 | One-cycle completion pulse |
| done_tag | output | 4 | Tag of the completed request |
| cnt_busy | output | 32 | Cycles the channel spent serving |
| cnt_reqs | output | 32 | Completed requests |
| cnt_pages | output | 32 | Rows opened (closed-page accesses) |
| cnt_bytes | output | 32 | Bytes moved by completed requests |

## Verification
The bench targets several corner cases:
- The first touch of each bank after reset. A design that starts with row zero open would charge T_OPEN there.
- A return to a row that was closed by another row in the same bank. A design that keeps a single global open row, or never replaces the row, gets this wrong.
- Mode switches while rows stay open. If the two bank fields are swapped or overlap, the hit/miss pattern changes, and so do the completion times.
- A queue driven to full. This catches a design that frees the slot at issue rather than at completion, or that pops a request early, which would show as a wrong `req_ready` or out-of-order tags.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_BUSY = 1'b1
    } chan_state_e;

    typedef enum logic {
        MAP_ROW   = 1'b0,
        MAP_BLOCK = 1'b1
    } map_mode_e;

    // Power-of-two width helper for bank indices
    function automatic int idx_width(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/dcc_req_fifo.sv
module dcc_req_fifo #(
    parameter int W     = 36,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH <= 1) ? 1 : $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign dout  = mem[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push && !full) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop && !empty) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({push && !full, pop && !empty})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/dcc_addr_map.sv
module dcc_addr_map
    import dcc_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int BANK_W     = 3,
    parameter int PAGE_LOG2  = 6,
    parameter int BLOCK_LOG2 = 4
) (
    input  logic [ADDR_W-1:0]                  addr,
    input  map_mode_e                          mode,
    output logic [BANK_W-1:0]                  bank,
    output logic [ADDR_W-PAGE_LOG2-BANK_W-1:0] row
);
    localparam int ROW_LSB = PAGE_LOG2 + BANK_W;

    // Row is identical in both modes because the block size never exceeds the page
    assign row = addr[ADDR_W-1:ROW_LSB];

    always_comb begin
        if (mode == MAP_BLOCK) bank = addr[BLOCK_LOG2 +: BANK_W];
        else                   bank = addr[PAGE_LOG2  +: BANK_W];
    end
endmodule

// File: rtl/dcc_page_table.sv
module dcc_page_table #(
    parameter int BANKS  = 8,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] lk_bank,
    input  logic [ROW_W-1:0]  lk_row,
    output logic              hit,
    input  logic              upd_en
);
    logic             open_vld [BANKS];
    logic [ROW_W-1:0] open_row [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                open_vld[b] <= 1'b0;
                open_row[b] <= '0;
            end else if (upd_en && lk_bank == BANK_W'(b)) begin
                open_vld[b] <= 1'b1;
                open_row[b] <= lk_row;
            end
        end
    end

    assign hit = open_vld[lk_bank] && (open_row[lk_bank] == lk_row);
endmodule

// File: rtl/dram_chan_ctrl.sv
module dram_chan_ctrl
    import dcc_pkg::*;
#(
    parameter int ADDR_W         = 24,
    parameter int LEN_W          = 8,
    parameter int TAG_W          = 4,
    parameter int DEPTH          = 4,
    parameter int MODULES        = 2,
    parameter int RANKS          = 2,
    parameter int BANKS_PER_RANK = 2,
    parameter int PAGE_LOG2      = 6,
    parameter int BLOCK_LOG2     = 4,
    parameter int T_OPEN         = 2,
    parameter int T_CLOSED       = 5,
    parameter int CNT_W          = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              map_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_bytes,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              done_valid,
    output logic [TAG_W-1:0]  done_tag,
    output logic [CNT_W-1:0]  cnt_busy,
    output logic [CNT_W-1:0]  cnt_reqs,
    output logic [CNT_W-1:0]  cnt_pages,
    output logic [CNT_W-1:0]  cnt_bytes
);
    localparam int BANKS  = MODULES * RANKS * BANKS_PER_RANK;
    localparam int BANK_W = idx_width(BANKS);
    localparam int ROW_W  = ADDR_W - PAGE_LOG2 - BANK_W;
    localparam int ENT_W  = ADDR_W + LEN_W + TAG_W;
    localparam int REM_W  = $clog2(T_CLOSED + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  bytes;
        logic [TAG_W-1:0]  tag;
    } req_t;

    req_t              in_req, head;
    logic [ENT_W-1:0]  head_raw;
    logic              q_full, q_empty, q_pop;
    logic [BANK_W-1:0] head_bank;
    logic [ROW_W-1:0]  head_row;
    logic              page_hit, start;
    chan_state_e       state;
    logic [REM_W-1:0]  remaining;
    logic              in_service;

    assign in_req    = '{addr: req_addr, bytes: req_bytes, tag: req_tag};
    assign head      = req_t'(head_raw);
    assign req_ready = !q_full;
    assign start     = (state == CH_IDLE) && !q_empty;
    assign q_pop     = (state == CH_BUSY) && (remaining == REM_W'(1));
    assign in_service = (state == CH_BUSY);

    dcc_req_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_queue (
        .clk   (clk),
        .rst   (rst),
        .push  (req_valid),
        .din   (in_req),
        .pop   (q_pop),
        .dout  (head_raw),
        .full  (q_full),
        .empty (q_empty)
    );

    dcc_addr_map #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W),
        .PAGE_LOG2(PAGE_LOG2), .BLOCK_LOG2(BLOCK_LOG2)
    ) u_map (
        .addr (head.addr),
        .mode (map_mode_e'(map_mode)),
        .bank (head_bank),
        .row  (head_row)
    );

    dcc_page_table #(.BANKS(BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_pages (
        .clk     (clk),
        .rst     (rst),
        .lk_bank (head_bank),
        .lk_row  (head_row),
        .hit     (page_hit),
        .upd_en  (start)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= CH_IDLE;
            remaining  <= '0;
            done_valid <= 1'b0;
            done_tag   <= '0;
            cnt_busy   <= '0;
            cnt_reqs   <= '0;
            cnt_pages  <= '0;
            cnt_bytes  <= '0;
        end else begin
            done_valid <= 1'b0;
            case (state)
                CH_IDLE: begin
                    if (start) begin
                        state     <= CH_BUSY;
                        remaining <= page_hit ? REM_W'(T_OPEN) : REM_W'(T_CLOSED);
                        if (!page_hit) cnt_pages <= cnt_pages + 1'b1;
                    end
                end
                CH_BUSY: begin
                    cnt_busy <= cnt_busy + 1'b1;
                    if (q_pop) begin
                        state      <= CH_IDLE;
                        done_valid <= 1'b1;
                        done_tag   <= head.tag;
                        cnt_reqs   <= cnt_reqs + 1'b1;
                        cnt_bytes  <= cnt_bytes + CNT_W'(head.bytes);
                    end else begin
                        remaining <= remaining - 1'b1;
                    end
                end
                default: state <= CH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             done_valid,
    input logic             in_service,
    input logic [CNT_W-1:0] cnt_busy,
    input logic [CNT_W-1:0] cnt_reqs,
    input logic [CNT_W-1:0] cnt_pages
);
    // R9: completion is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid);

    // R1: a completion only follows the end of a service period
    assert_done_after_service_R1: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> $fell(in_service));

    // R2: the queue can only become full because a request was pushed
    assert_fill_by_push_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(req_ready) |-> $past(req_valid));

    // R7: request counter advances with each completion
    assert_req_count_R7: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> cnt_reqs == $past(cnt_reqs) + 1'b1);

    // R7: busy counter advances once per serving cycle
    assert_busy_step_R7: assert property (@(posedge clk) disable iff (rst)
        $past(in_service) |-> cnt_busy == $past(cnt_busy) + 1'b1);

    // R4: pages are opened only when a service period begins
    assert_page_on_start_R4: assert property (@(posedge clk) disable iff (rst)
        (cnt_pages != $past(cnt_pages)) |-> $rose(in_service));
endmodule

bind dram_chan_ctrl dcc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .done_valid (done_valid),
    .in_service (in_service),
    .cnt_busy   (cnt_busy),
    .cnt_reqs   (cnt_reqs),
    .cnt_pages  (cnt_pages)
);

// File: tb/dram_chan_ctrl_bench.sv
module dram_chan_ctrl_bench;
    localparam int DEPTH = 4;
    localparam int TOPEN = 2;
    localparam int TCLOSED = 5;
    localparam int MAXQ = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        map_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic [7:0]  req_bytes = '0;
    logic [3:0]  req_tag = '0;
    logic        done_valid;
    logic [3:0]  done_tag;
    logic [31:0] cnt_busy, cnt_reqs, cnt_pages, cnt_bytes;

    always #10 clk = ~clk;  // 50 MHz

    dram_chan_ctrl u_dram_chan_ctrl (
        .clk(clk), .rst(rst), .map_mode(map_mode),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_bytes(req_bytes), .req_tag(req_tag),
        .done_valid(done_valid), .done_tag(done_tag),
        .cnt_busy(cnt_busy), .cnt_reqs(cnt_reqs),
        .cnt_pages(cnt_pages), .cnt_bytes(cnt_bytes)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard of accepted requests
    logic [23:0] q_addr [MAXQ];
    logic [7:0]  q_bytes [MAXQ];
    logic [3:0]  q_tag [MAXQ];
    logic        q_mode [MAXQ];
    longint      q_cyc [MAXQ];
    int          acc = 0;
    int          completed = 0;
    longint      cyc = 0;
    longint      prev_done_edge = 0;
    longint      exp_busy = 0, exp_pages = 0, exp_bytes = 0;
    bit          m_vld [8];
    logic [14:0] m_row [8];
    int          full_seen = 0;

    // R5/R6 decode, written from the requirement bit positions
    function automatic int bank_of(input logic [23:0] a, input logic mode);
        return mode ? int'(a[6:4]) : int'(a[8:6]);
    endfunction
    function automatic logic [14:0] row_of(input logic [23:0] a);
        return a[23:9];
    endfunction
    function automatic longint lmax(input longint a, input longint b);
        return (a > b) ? a : b;
    endfunction

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst && req_valid && req_ready) begin
            q_addr[acc % MAXQ]  = req_addr;
            q_bytes[acc % MAXQ] = req_bytes;
            q_tag[acc % MAXQ]   = req_tag;
            q_mode[acc % MAXQ]  = map_mode;
            q_cyc[acc % MAXQ]   = cyc;
            acc = acc + 1;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (done_valid) begin
                int i, b, lat;
                bit hit;
                longint exp_edge;
                string rq;
                i = completed % MAXQ;
                b = bank_of(q_addr[i], q_mode[i]);
                hit = m_vld[b] && (m_row[b] == row_of(q_addr[i]));
                lat = hit ? TOPEN : TCLOSED;
                m_vld[b] = 1'b1;
                m_row[b] = row_of(q_addr[i]);
                exp_edge = lmax(q_cyc[i], prev_done_edge) + 1 + lat;
                rq = {hit ? "R3" : "R4", q_mode[i] ? " R6" : " R5", " R9 completion edge"};
                chk(completed < acc, "R1 completion without request", completed, acc);
                chk(done_tag == q_tag[i], "R1 done_tag", done_tag, q_tag[i]);
                chk(cyc == exp_edge, rq, cyc, exp_edge);
                exp_busy  += lat;
                exp_pages += hit ? 0 : 1;
                exp_bytes += q_bytes[i];
                chk(cnt_busy == exp_busy, "R7 cnt_busy", cnt_busy, exp_busy);
                chk(cnt_reqs == completed + 1, "R7 cnt_reqs", cnt_reqs, completed + 1);
                chk(cnt_pages == exp_pages, "R7 cnt_pages R4", cnt_pages, exp_pages);
                chk(cnt_bytes == exp_bytes, "R7 cnt_bytes", cnt_bytes, exp_bytes);
                prev_done_edge = cyc;
                completed = completed + 1;
            end
            // R2: ready tracks occupancy (in-service request still held)
            chk(req_ready == ((acc - completed) < DEPTH), "R2 req_ready",
                req_ready, (acc - completed) < DEPTH);
            if (!req_ready) full_seen++;
        end
    end

    task automatic push(input logic [23:0] a, input logic [7:0] n, input logic [3:0] t);
        @(negedge clk); #1;
        req_valid = 1'b1;
        req_addr  = a;
        req_bytes = n;
        req_tag   = t;
        while (!req_ready) begin
            @(negedge clk); #1;
        end
        @(posedge clk);
    endtask

    task automatic release_bus();
        @(negedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        release_bus();
        while (completed != acc) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk); #1;
        map_mode = m;
    endtask

    bit timed_out = 0;

    initial begin
        int seed;
        seed = $urandom(20240611);
        for (int b = 0; b < 8; b++) begin
            m_vld[b] = 1'b0;
            m_row[b] = '0;
        end
        fork
            begin
                repeat (3) @(posedge clk);
                @(negedge clk); #1;
                rst = 1'b0;
                @(negedge clk);
                // R8: reset state
                chk(req_ready == 1'b1, "R8 req_ready after reset", req_ready, 1);
                chk(done_valid == 1'b0, "R8 done_valid after reset", done_valid, 0);
                chk(cnt_busy == 0 && cnt_reqs == 0, "R8 busy/reqs counters", cnt_busy + cnt_reqs, 0);
                chk(cnt_pages == 0 && cnt_bytes == 0, "R8 pages/bytes counters", cnt_pages + cnt_bytes, 0);

                // Directed, row interleave (R5): first touch, hit, other bank, row change, reopen
                set_mode(1'b0);
                push(24'h000000, 8'd16, 4'h1);
                drain();
                push(24'h000010, 8'd8, 4'h2);   // same page: R3 hit
                drain();
                push(24'h000040, 8'd4, 4'h3);   // bank 1 first touch: R4
                push(24'h000200, 8'd32, 4'h4);  // bank 0 row 1: R4
                push(24'h000000, 8'd1, 4'h5);   // bank 0 row 0 again: R4
                push(24'h000004, 8'd2, 4'h6);   // hit
                drain();

                // Block interleave (R6): open rows kept across mode switch
                set_mode(1'b1);
                push(24'h000010, 8'd64, 4'h7);  // bank 1 row 0: open from 0x040 -> hit
                push(24'h000020, 8'd64, 4'h8);  // bank 2 first touch
                push(24'h000230, 8'd9, 4'h9);   // bank 3 row 1
                push(24'h000000, 8'd3, 4'hA);   // bank 0 row 0 hit
                drain();

                // Queue fill (R2): same bank, alternating rows, streamed
                set_mode(1'b0);
                full_seen = 0;
                for (int k = 0; k < 8; k++)
                    push({13'd0, k[0], 10'd0}, 8'(k + 1), 4'(k));
                drain();
                chk(full_seen > 0, "R2 queue reached full", full_seen, 1);

                // Random batches
                for (int bt = 0; bt < 12; bt++) begin
                    set_mode(1'($urandom & 1));
                    for (int k = 0; k < 20; k++)
                        push(24'($urandom % 2048), 8'(1 + $urandom % 255), 4'($urandom));
                    drain();
                end
                chk(cnt_reqs == acc, "R7 final request total", cnt_reqs, acc);
            end
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) chk(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule